// File: doc/BRIEF.md
# Flag-Setting Adder with Conditional Compare

This block is the integer add and compare slice of an execution pipe. It adds two operands and a carry at either a narrow or a wide width. It can also apply a bitwise AND, OR or exclusive-OR. A four-bit status register holds negative, zero, carry and overflow, and the block updates it when a flag-setting operation is presented with a valid strobe.

For the two conditional-compare operations, the block first tests a four-bit condition code against the status register it currently holds. If the test passes, the new flags come from an addition or a subtraction of the operands. If the test fails, the new flags are copied from a four-bit immediate.

The result output is combinational from the inputs. The flags appear on the cycle after the strobed operation.

Top module: `flag_adder_cc`

## Requirements
- R1: The selected width is DATA_W bits when `wideSel` is 1 and DATA_W/2 bits when it is 0. Both operands are cut to that width before use. `result` equals the sum of the operands and the carry taken modulo 2^width, and every bit of `result` above the selected width is zero.
- R2: After a flag-setting arithmetic operation, bit 3 of `flags` (N) equals the top bit of the result at the selected width. Bit 2 of `flags` (Z) is 1 exactly when the result is zero.
- R3: After a flag-setting arithmetic operation, bit 1 of `flags` (C) is 1 exactly when the unsigned sum of both operands and the carry exceeds 2^width - 1.
- R4: After a flag-setting arithmetic operation, bit 0 of `flags` (V) is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R5: Opcode 3 is a flag-setting AND. `result` is the AND of the operands, N and Z come from that result, and C and V become 0.
- R6: Opcodes 0 (add with `carryIn`), 2 (AND), 4 (OR) and 5 (exclusive-OR) drive `result` and leave `flags` unchanged. Opcode 1 is the same add with flags updated.
- R7: Opcode 6 is compare-negative. When its condition passes, the flags are set as for `opA + opB` with carry 0.
- R8: Opcode 7 is compare. When its condition passes, the flags are set as for `opA + ~opB` with carry 1. For both compare opcodes, `result` carries that arithmetic value whether or not the condition passes.
- R9: When the condition of opcode 6 or 7 fails, `flags` are loaded from `nzcvImm`, with bit 3 going to N, bit 2 to Z, bit 1 to C and bit 0 to V.
- R10: Condition codes 0 to 15 test the current flags as follows: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !(C&!Z); 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 its inverse; 14 and 15 always pass.
- R11: `flags` change only on a rising clock edge at which `valid` is 1.
- R12: An active-low `rstN` clears `flags` to 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Qualifies the operation for a flag update |
| wideSel | input | 1 | 1 selects DATA_W bits, 0 selects DATA_W/2 bits |
| opSel | input | 3 | Opcode 0..7 (see R5 to R9) |
| cond | input | 4 | Condition code for the compare opcodes |
| nzcvImm | input | 4 | Flags used when a compare's condition fails |
| carryIn | input | 1 | Carry for opcodes 0 and 1 |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| result | output | DATA_W | Combinational result |
| flags | output | 4 | Registered N, Z, C, V (bit 3 down to bit 0) |

## Verification
The assertions check the following on every cycle:
- the flags hold without `valid` and under the non-flag opcodes;
- the flag-setting AND clears C and V;
- N and Z of a flag-setting add match the previous result;
- a failed equal-condition compare copies the immediate;
- the upper half of `result` is zero in narrow mode.

The carry and overflow arithmetic, and the full sixteen-entry condition table against every flag state, can only be shown by the bench. The bench sweeps every operand pair at the narrow width and computes the expected sums and flags arithmetically. The bench also covers reset taken while the flags are non-zero.

// File: rtl/fadd_pkg.sv
package fadd_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDS = 3'd1,
    OP_AND  = 3'd2,
    OP_ANDS = 3'd3,
    OP_ORR  = 3'd4,
    OP_EOR  = 3'd5,
    OP_CCMN = 3'd6,
    OP_CCMP = 3'd7
  } opKind_e;

  typedef enum logic [1:0] {
    FS_ARITH = 2'd0,
    FS_LOGIC = 2'd1,
    FS_IMM   = 2'd2
  } flagSrc_e;

  typedef enum logic [1:0] {
    CS_INPUT = 2'd0,
    CS_ZERO  = 2'd1,
    CS_ONE   = 2'd2
  } carrySel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_ORR = 2'd1,
    LG_EOR = 2'd2
  } logicOp_e;

  typedef struct packed {
    logic      flagLoad;
    flagSrc_e  flagSrc;
    logic      invertB;
    carrySel_e carrySel;
    logicOp_e  logicOp;
    logic      pickLogic;
  } ctrlStrobe_t;

  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/fadd_cond_eval.sv
module fadd_cond_eval
  import fadd_pkg::*;
(
  input  logic [3:0]        cond,
  input  logic [FLAG_W-1:0] curFlags,
  output logic              condPass
);

  logic n, z, c, v;
  logic baseTest;

  assign n = curFlags[FLAG_N];
  assign z = curFlags[FLAG_Z];
  assign c = curFlags[FLAG_C];
  assign v = curFlags[FLAG_V];

  // Even codes test a predicate; odd codes invert it; 14 and 15 always pass.
  always_comb begin
    unique case (cond[3:1])
      3'd0:    baseTest = z;
      3'd1:    baseTest = c;
      3'd2:    baseTest = n;
      3'd3:    baseTest = v;
      3'd4:    baseTest = c & ~z;
      3'd5:    baseTest = (n == v);
      3'd6:    baseTest = ~z & (n == v);
      default: baseTest = 1'b1;
    endcase
  end

  assign condPass = (cond[3:1] == 3'd7) ? 1'b1 : (baseTest ^ cond[0]);

endmodule

// File: rtl/fadd_ctrl.sv
module fadd_ctrl
  import fadd_pkg::*;
(
  input  logic              valid,
  input  logic [2:0]        opSel,
  input  logic [3:0]        cond,
  input  logic [FLAG_W-1:0] curFlags,
  output ctrlStrobe_t       strobe
);

  opKind_e opKind;
  logic    condPass;

  assign opKind = opKind_e'(opSel);

  fadd_cond_eval u_condEval (
    .cond     (cond),
    .curFlags (curFlags),
    .condPass (condPass)
  );

  always_comb begin
    strobe.flagLoad  = 1'b0;
    strobe.flagSrc   = FS_ARITH;
    strobe.invertB   = 1'b0;
    strobe.carrySel  = CS_INPUT;
    strobe.logicOp   = LG_AND;
    strobe.pickLogic = 1'b0;
    unique case (opKind)
      OP_ADD: begin
      end
      OP_ADDS: begin
        strobe.flagLoad = valid;
      end
      OP_AND: begin
        strobe.pickLogic = 1'b1;
      end
      OP_ANDS: begin
        strobe.pickLogic = 1'b1;
        strobe.flagLoad  = valid;
        strobe.flagSrc   = FS_LOGIC;
      end
      OP_ORR: begin
        strobe.pickLogic = 1'b1;
        strobe.logicOp   = LG_ORR;
      end
      OP_EOR: begin
        strobe.pickLogic = 1'b1;
        strobe.logicOp   = LG_EOR;
      end
      OP_CCMN: begin
        strobe.carrySel = CS_ZERO;
        strobe.flagLoad = valid;
        strobe.flagSrc  = condPass ? FS_ARITH : FS_IMM;
      end
      OP_CCMP: begin
        strobe.invertB  = 1'b1;
        strobe.carrySel = CS_ONE;
        strobe.flagLoad = valid;
        strobe.flagSrc  = condPass ? FS_ARITH : FS_IMM;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/fadd_datapath.sv
module fadd_datapath
  import fadd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              wideSel,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FLAG_W-1:0] nzcvImm,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] aMasked, bMasked;
  logic              cinBit;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] arithRes, logicRes;
  logic              carryOut, overflow;
  logic [FLAG_W-1:0] nextFlags;

  function automatic logic signAt(input logic [DATA_W-1:0] x, input logic wide);
    return wide ? x[DATA_W-1] : x[HALF_W-1];
  endfunction

  assign widthMask = wideSel ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  assign aMasked   = opA & widthMask;
  assign bMasked   = (strobe.invertB ? ~opB : opB) & widthMask;

  always_comb begin
    unique case (strobe.carrySel)
      CS_ZERO: cinBit = 1'b0;
      CS_ONE:  cinBit = 1'b1;
      default: cinBit = carryIn;
    endcase
  end

  assign sumFull  = {1'b0, aMasked} + {1'b0, bMasked} + {{DATA_W{1'b0}}, cinBit};
  assign arithRes = sumFull[DATA_W-1:0] & widthMask;
  // With both operands masked, the carry lands in the bit just past the width.
  assign carryOut = wideSel ? sumFull[DATA_W] : sumFull[HALF_W];
  assign overflow = (signAt(aMasked, wideSel) == signAt(bMasked, wideSel)) &&
                    (signAt(arithRes, wideSel) != signAt(aMasked, wideSel));

  always_comb begin
    unique case (strobe.logicOp)
      LG_ORR:  logicRes = (opA | opB) & widthMask;
      LG_EOR:  logicRes = (opA ^ opB) & widthMask;
      default: logicRes = (opA & opB) & widthMask;
    endcase
  end

  assign result = strobe.pickLogic ? logicRes : arithRes;

  always_comb begin
    unique case (strobe.flagSrc)
      FS_LOGIC: nextFlags = {signAt(logicRes, wideSel), (logicRes == '0), 1'b0, 1'b0};
      FS_IMM:   nextFlags = nzcvImm;
      default:  nextFlags = {signAt(arithRes, wideSel), (arithRes == '0), carryOut, overflow};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else if (strobe.flagLoad) begin
      flags <= nextFlags;
    end
  end

endmodule

// File: rtl/flag_adder_cc.sv
module flag_adder_cc
  import fadd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic              wideSel,
  input  logic [2:0]        opSel,
  input  logic [3:0]        cond,
  input  logic [3:0]        nzcvImm,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags
);

  ctrlStrobe_t strobe;

  fadd_ctrl u_ctrl (
    .valid    (valid),
    .opSel    (opSel),
    .cond     (cond),
    .curFlags (flags),
    .strobe   (strobe)
  );

  fadd_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wideSel (wideSel),
    .carryIn (carryIn),
    .opA     (opA),
    .opB     (opB),
    .nzcvImm (nzcvImm),
    .result  (result),
    .flags   (flags)
  );

endmodule

// File: rtl/flag_adder_cc_checker.sv
module flag_adder_cc_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              valid,
  input logic              wideSel,
  input logic [2:0]        opSel,
  input logic [3:0]        cond,
  input logic [3:0]        nzcvImm,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags
);

  localparam int HALF_W = DATA_W / 2;

  // R11: no strobe, no flag change
  a_r11_hold_without_valid: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> $stable(flags));

  // R6: non-flag opcodes keep the flags
  a_r6_nonflag_keep: assert property (@(posedge clk) disable iff (!rstN)
    (valid && (opSel == 3'd0 || opSel == 3'd2 || opSel == 3'd4 || opSel == 3'd5))
    |=> $stable(flags));

  // R5: flag-setting AND clears C and V
  a_r5_ands_cv_clear: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opSel == 3'd3) |=> (flags[1:0] == 2'b00));

  // R2: Z after a flag-setting add reflects the result seen at the edge
  a_r2_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opSel == 3'd1) |=> (flags[2] == ($past(result) == '0)));

  // R2: N after a flag-setting add is the top bit at the selected width
  a_r2_neg_flag: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opSel == 3'd1) |=>
    (flags[3] == ($past(wideSel) ? $past(result[DATA_W-1]) : $past(result[HALF_W-1]))));

  // R9: compare with a failing equal-condition loads the immediate
  a_r9_imm_load: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opSel == 3'd7 && cond == 4'd0 && !flags[2]) |=> (flags == $past(nzcvImm)));

  // R1: narrow width leaves the upper half of the result at zero
  a_r1_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    !wideSel |-> (result[DATA_W-1:HALF_W] == '0));

endmodule

bind flag_adder_cc flag_adder_cc_checker #(.DATA_W(DATA_W)) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .valid   (valid),
  .wideSel (wideSel),
  .opSel   (opSel),
  .cond    (cond),
  .nzcvImm (nzcvImm),
  .result  (result),
  .flags   (flags)
);

// File: tb/flag_adder_cc_bench.sv
module flag_adder_cc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int HW = DW / 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          valid = 1'b0;
  logic          wideSel = 1'b0;
  logic [2:0]    opSel = '0;
  logic [3:0]    cond = '0;
  logic [3:0]    nzcvImm = '0;
  logic          carryIn = 1'b0;
  logic [DW-1:0] opA = '0;
  logic [DW-1:0] opB = '0;
  logic [DW-1:0] result;
  logic [3:0]    flags;

  int       nChecks = 0;
  int       nFails = 0;
  bit       summaryDone = 0;
  logic [3:0] expFlags = '0;
  string    prevTag = "R12";

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_adder_cc #(.DATA_W(DW)) u_flag_adder_cc (
    .clk(clk), .rstN(rstN), .valid(valid), .wideSel(wideSel), .opSel(opSel),
    .cond(cond), .nzcvImm(nzcvImm), .carryIn(carryIn), .opA(opA), .opB(opB),
    .result(result), .flags(flags)
  );

  task automatic checkVal(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic bit condOk(int c, logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0:  return z;
      1:  return !z;
      2:  return cy;
      3:  return !cy;
      4:  return n;
      5:  return !n;
      6:  return v;
      7:  return !v;
      8:  return cy && !z;
      9:  return !(cy && !z);
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return !(!z && (n == v));
      default: return 1;
    endcase
  endfunction

  // Applies one operation; checks the previous operation's flags first.
  task automatic runOp(int op, int cd, int imm, int cin, int wide, int a, int b,
                       int vld, string tag);
    int w, m, am, bm, bb, ci, s, ares, lres, sb, expRes;
    bit fn, fz, fc, fv;
    @(negedge clk);
    checkVal(prevTag, "flags", int'(flags), int'(expFlags));
    opSel = op[2:0]; cond = cd[3:0]; nzcvImm = imm[3:0]; carryIn = cin[0];
    wideSel = wide[0]; opA = a[DW-1:0]; opB = b[DW-1:0]; valid = vld[0];
    #1;
    w  = wide ? DW : HW;
    m  = (1 << w) - 1;
    sb = w - 1;
    am = a & m;
    bm = b & m;
    bb = (op == 7) ? (~b & m) : bm;
    ci = (op == 6) ? 0 : (op == 7) ? 1 : cin;
    s    = am + bb + ci;
    ares = s & m;
    case (op)
      4: lres = am | bm;
      5: lres = am ^ bm;
      default: lres = am & bm;
    endcase
    expRes = (op == 2 || op == 3 || op == 4 || op == 5) ? lres : ares;
    checkVal(tag, "result", int'(result), expRes);
    if (vld != 0) begin
      fn = ((ares >> sb) & 1) == 1;
      fz = (ares == 0);
      fc = (s > m);
      fv = (((am >> sb) & 1) == ((bb >> sb) & 1)) && (((ares >> sb) & 1) != ((am >> sb) & 1));
      if (op == 1) expFlags = {fn, fz, fc, fv};
      else if (op == 3) expFlags = {((lres >> sb) & 1) == 1, lres == 0, 1'b0, 1'b0};
      else if (op == 6 || op == 7)
        expFlags = condOk(cd, expFlags) ? {fn, fz, fc, fv} : imm[3:0];
    end
    prevTag = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    string t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkVal("R12", "flags at reset", int'(flags), 0);
    checkVal("R1", "result at reset", int'(result), 0);
    rstN = 1'b1;

    // R3 R2 R4: exhaustive narrow flag-setting add
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++)
          runOp(1, 0, 0, c, 0, a + 16 * ((a + b) & 15), b + 16 * (b & 7), 1, "R3");

    // R1 R4: wide flag-setting add samples
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 13)
        runOp(1, 0, 0, (a ^ b) & 1, 1, a, b, 1, "R4");

    // R1: plain add at both widths (flags untouched, R6)
    for (int a = 0; a < 256; a += 29)
      for (int b = 0; b < 256; b += 31) begin
        runOp(0, 0, 0, 1, 0, a, b, 1, "R1");
        runOp(0, 0, 0, 0, 1, a, b, 1, "R6");
      end

    // R5 R6: logic opcodes, narrow exhaustive with high garbage bits
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        runOp(3, 0, 0, 0, 0, a | 8'hA0, b | 8'h50, 1, "R5");
        runOp(2, 0, 0, 0, 0, a, b, 1, "R6");
        runOp(4, 0, 0, 0, 1, a * 16, b, 1, "R6");
        runOp(5, 0, 0, 0, 0, a, b, 1, "R6");
      end
    runOp(3, 0, 0, 0, 1, 8'hF0, 8'h90, 1, "R5");

    // R10 R7 R8 R9: every condition code against every flag state
    for (int f = 0; f < 16; f++)
      for (int c = 0; c < 16; c++)
        for (int k = 6; k < 8; k++) begin
          runOp(1, 0, 0, 0, 0, 1, 0, 1, "R10");
          runOp(7, 0, f, 0, 0, 3, 5, 1, "R9");
          if (condOk(c, f[3:0])) t = (k == 6) ? "R7" : "R8";
          else t = "R9";
          runOp(k, c, ~f & 15, 1, (f + c) & 1, f * 16 + c, c * 16 + f, 1, t);
          runOp(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        end

    // R11: strobe low holds the flags
    runOp(7, 0, 4'hB, 0, 0, 0, 0, 1, "R9");
    for (int a = 0; a < 16; a++)
      runOp(1 + 2 * (a & 1), 0, 0, 0, 0, a, 15 - a, 0, "R11");
    runOp(6, 14, 0, 0, 0, 0, 0, 0, "R11");
    runOp(0, 0, 0, 0, 0, 0, 0, 0, "R11");

    // R12: reset while flags non-zero
    runOp(7, 0, 4'hF, 0, 0, 0, 0, 1, "R9");
    runOp(0, 0, 0, 0, 0, 0, 0, 0, "R12");
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkVal("R12", "flags after mid-run reset", int'(flags), 0);
    @(negedge clk);
    rstN = 1'b1;
    expFlags = '0;
    runOp(0, 0, 0, 0, 0, 0, 0, 0, "R12");
    runOp(0, 0, 0, 0, 0, 0, 0, 0, "R12");
    finishRun();
  end

endmodule